// File: doc/BRIEF.md
# Octal Double-Buffered Serial Converter Register Core

This block is the digital control core of an eight-channel, 12-bit converter. A host frames 16-bit command words on a three-wire serial port: an active-low frame select, a serial clock and a serial data line. Each word carries a 4-bit command code followed by a 12-bit unsigned binary code, both sent most significant bit first. The core runs on its own system clock. It synchronizes the serial pins, samples data on falling serial clock edges, and acts on a word only when exactly 16 bits were framed.

Every channel has two 12-bit stages. The staging register holds the last value written to that channel. The output register holds the code the converter presents. Staged values move to the outputs in one of two ways: a command that copies all channels at once, or an active-low transfer pin. While that pin is held low, every output register follows its staging register. A serial chain output passes on the bits that fall off the end of the shift register, so several devices can be cascaded on one port. An active-low wipe pin clears all staging and output registers at once, without waiting for a clock edge.

Top module: `octal_dac_core`

## Requirements
- R1: After reset, every output code is zero and `chain_out` is 0.
- R2: A word is 16 bits, sent MSB first. Bits 15:12 are the command and bits 11:0 are the data. Commands 0 to 7 load the data into the staging register of that channel only. Channel i appears on `dac_code[12*i +: 12]`.
- R3: While `xfer_n` is high, a write to a staging register leaves every output code unchanged.
- R4: Command 8 copies all eight staging registers into their output registers in the same cycle.
- R5: Command 9 loads the data into all eight staging registers and all eight output registers.
- R6: Commands 10 to 15 change no register.
- R7: When the frame closes after any bit count other than 16, including 15, 17 and 32, the word is dropped and no register changes.
- R8: While `xfer_n` is low, each output code follows its staging register. This includes writes made during that time.
- R9: A low level on `wipe_n` zeroes all staging and output registers at once, with no clock edge needed.
- R10: `chain_out` gives the bit shifted out of the 16-bit shift register. After the k-th falling serial clock edge of a frame (k > 16), it equals the (k-16)-th bit sent in that frame.
- R11: Falling serial clock edges seen while `frame_n` is high shift nothing, and `chain_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| frame_n | input | 1 | Serial frame select, active low |
| ser_clk | input | 1 | Serial clock, data sampled on falling edges |
| ser_data | input | 1 | Serial data, MSB first |
| xfer_n | input | 1 | Level-sensitive staging-to-output transfer, active low |
| wipe_n | input | 1 | Asynchronous clear of all channel registers, active low |
| chain_out | output | 1 | Cascade data output |
| dac_code | output | 96 | Eight 12-bit output codes, channel i at bits 12*i+11:12*i |

## Verification
Each serial pin passes through two synchronizer flops before edge detection. A closing frame is therefore registered on the third system clock edge after `frame_n` rises, and the output codes change on the fourth. A serial clock fall moves `chain_out` on the third edge. A change on `xfer_n` reaches the outputs on the third edge. The bench holds every serial phase for at least four clocks and waits eight clocks after each frame closes, so every sample falls after the due edge, mid-cycle, and before the next stimulus. The wipe is checked 1 ns after `wipe_n` falls, which shows the clear needs no clock edge.

// File: rtl/octdac_pkg.sv
package octdac_pkg;
    localparam int NUM_CH      = 8;
    localparam int CODE_W      = 12;
    localparam int CMD_W       = 4;
    localparam int FRAME_W     = CMD_W + CODE_W;
    localparam logic [CMD_W-1:0] CMD_COPY_ALL  = 4'd8;
    localparam logic [CMD_W-1:0] CMD_WRITE_ALL = 4'd9;
endpackage

// File: rtl/octdac_serial_rx.sv
module octdac_serial_rx #(
    parameter int FRAME_W = octdac_pkg::FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_n,
    input  logic               ser_clk,
    input  logic               ser_data,
    output logic               chain_out,
    output logic [FRAME_W-1:0] word_o,
    output logic               valid_o
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    // pin vector order: {frame, sclk, data}
    typedef struct packed {
        logic [2:0]         s1;
        logic [2:0]         s2;
        logic               sclk_prev;
        logic               frame_prev;
        logic [FRAME_W-1:0] shift;
        logic [CNT_W-1:0]   cnt;
        logic               chain;
        logic [FRAME_W-1:0] word;
        logic               valid;
    } rx_t;

    rx_t q, d;
    logic frame_fall, frame_rise, sclk_fall;

    always_comb begin
        d            = q;
        d.s1         = {frame_n, ser_clk, ser_data};
        d.s2         = q.s1;
        d.sclk_prev  = q.s2[1];
        d.frame_prev = q.s2[2];
        d.valid      = 1'b0;
        frame_fall   = q.frame_prev & ~q.s2[2];
        frame_rise   = ~q.frame_prev & q.s2[2];
        sclk_fall    = q.sclk_prev & ~q.s2[1];
        if (frame_fall) begin
            d.cnt = '0;
        end else if (!q.s2[2] && sclk_fall) begin
            d.shift = {q.shift[FRAME_W-2:0], q.s2[0]};
            d.chain = q.shift[FRAME_W-1];
            if (q.cnt != CNT_SAT) begin
                d.cnt = q.cnt + 1'b1;
            end
        end
        if (frame_rise) begin
            d.valid = (q.cnt == CNT_FULL);
            d.word  = q.shift;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.s1         <= 3'b110;
            q.s2         <= 3'b110;
            q.sclk_prev  <= 1'b1;
            q.frame_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign chain_out = q.chain;
    assign word_o    = q.word;
    assign valid_o   = q.valid;

    // R11: no shifting, and so no chain movement, while the frame is closed
    assert_chain_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.s2[2] && q.frame_prev) |=> $stable(chain_out));

    // R7: a word is only presented at a frame close
    assert_valid_at_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (q.frame_prev && $past(q.cnt) == CNT_FULL));
endmodule

// File: rtl/octdac_cmd_decode.sv
module octdac_cmd_decode #(
    parameter int NUM_CH = octdac_pkg::NUM_CH,
    parameter int CODE_W = octdac_pkg::CODE_W,
    parameter int CMD_W  = octdac_pkg::CMD_W,
    localparam int FRAME_W = CMD_W + CODE_W
) (
    input  logic               valid_i,
    input  logic [FRAME_W-1:0] word_i,
    output logic [NUM_CH-1:0]  wr_mask,
    output logic               copy_all,
    output logic               load_all,
    output logic [CODE_W-1:0]  data_o
);
    logic [CMD_W-1:0] cmd;

    assign cmd      = word_i[FRAME_W-1 -: CMD_W];
    assign data_o   = word_i[CODE_W-1:0];
    assign copy_all = valid_i && (cmd == octdac_pkg::CMD_COPY_ALL);
    assign load_all = valid_i && (cmd == octdac_pkg::CMD_WRITE_ALL);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        assign wr_mask[i] = valid_i &&
            ((cmd == CMD_W'(i)) || (cmd == octdac_pkg::CMD_WRITE_ALL));
    end
endmodule

// File: rtl/octdac_chan_bank.sv
module octdac_chan_bank #(
    parameter int NUM_CH = octdac_pkg::NUM_CH,
    parameter int CODE_W = octdac_pkg::CODE_W
) (
    input  logic                     clk,
    input  logic                     arst_n,
    input  logic                     xfer_n,
    input  logic [NUM_CH-1:0]        wr_mask,
    input  logic                     copy_all,
    input  logic                     load_all,
    input  logic [CODE_W-1:0]        data_i,
    output logic [NUM_CH*CODE_W-1:0] dac_flat
);
    typedef struct packed {
        logic [1:0]                   xs;
        logic [NUM_CH-1:0][CODE_W-1:0] stage;
        logic [NUM_CH-1:0][CODE_W-1:0] dac;
    } bank_t;

    bank_t q, d;
    logic  follow;

    always_comb begin
        d      = q;
        d.xs   = {q.xs[0], xfer_n};
        follow = ~q.xs[1];
        for (int i = 0; i < NUM_CH; i++) begin
            if (wr_mask[i]) begin
                d.stage[i] = data_i;
            end
            if (load_all) begin
                d.dac[i] = data_i;
            end else if (copy_all || follow) begin
                d.dac[i] = q.stage[i];
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            q    <= '0;
            q.xs <= 2'b11;
        end else begin
            q <= d;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_out
        assign dac_flat[i*CODE_W +: CODE_W] = q.dac[i];
    end

    // R3: outputs hold while transfer is released and no copy or broadcast arrives
    assert_out_hold_R3: assert property (@(posedge clk) disable iff (!arst_n)
        (q.xs[1] && !copy_all && !load_all) |=> $stable(dac_flat));

    // R6 / R7: staging registers change only on a decoded write
    assert_stage_hold_R7: assert property (@(posedge clk) disable iff (!arst_n)
        (wr_mask == '0) |=> $stable(q.stage));

    // R2: at most one channel per single write, unless broadcasting
    assert_single_write_R2: assert property (@(posedge clk) disable iff (!arst_n)
        load_all || $onehot0(wr_mask));

    // R8: transparent transfer tracks staging with one cycle of lag
    assert_follow_R8: assert property (@(posedge clk) disable iff (!arst_n)
        (!q.xs[1] && !load_all) |=> (q.dac == $past(q.stage)));

    // R9: while the clear is active every register reads zero
    always @(negedge clk) begin
        if (!arst_n) begin
            assert_wiped_R9: assert (q.stage == '0 && q.dac == '0);
        end
    end
endmodule

// File: rtl/octal_dac_core.sv
module octal_dac_core #(
    parameter int NUM_CH = octdac_pkg::NUM_CH,
    parameter int CODE_W = octdac_pkg::CODE_W,
    parameter int CMD_W  = octdac_pkg::CMD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_n,
    input  logic                     ser_clk,
    input  logic                     ser_data,
    input  logic                     xfer_n,
    input  logic                     wipe_n,
    output logic                     chain_out,
    output logic [NUM_CH*CODE_W-1:0] dac_code
);
    localparam int FRAME_W = CMD_W + CODE_W;

    logic [FRAME_W-1:0] word;
    logic               word_vld;
    logic [NUM_CH-1:0]  wr_mask;
    logic               copy_all;
    logic               load_all;
    logic [CODE_W-1:0]  data;
    logic               bank_rst_n;

    assign bank_rst_n = rst_n & wipe_n;

    octdac_serial_rx #(.FRAME_W(FRAME_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .chain_out (chain_out),
        .word_o    (word),
        .valid_o   (word_vld)
    );

    octdac_cmd_decode #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .CMD_W(CMD_W)) u_dec (
        .valid_i  (word_vld),
        .word_i   (word),
        .wr_mask  (wr_mask),
        .copy_all (copy_all),
        .load_all (load_all),
        .data_o   (data)
    );

    octdac_chan_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_bank (
        .clk      (clk),
        .arst_n   (bank_rst_n),
        .xfer_n   (xfer_n),
        .wr_mask  (wr_mask),
        .copy_all (copy_all),
        .load_all (load_all),
        .data_i   (data),
        .dac_flat (dac_code)
    );
endmodule

// File: tb/sim_octal_dac_core.sv
`timescale 1ns/1ps
module sim_octal_dac_core;
    localparam int NCH = 8;
    localparam int DW  = 12;

    logic clk = 1'b0;
    logic rst_n, frame_n, ser_clk, ser_data, xfer_n, wipe_n;
    logic chain_out;
    logic [NCH*DW-1:0] dac_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] stage_m [NCH];
    logic [DW-1:0] dac_m   [NCH];

    always #10 clk = ~clk;

    octal_dac_core u0 (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ser_clk(ser_clk),
        .ser_data(ser_data), .xfer_n(xfer_n), .wipe_n(wipe_n),
        .chain_out(chain_out), .dac_code(dac_code)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    function automatic logic [NCH*DW-1:0] packed_model();
        logic [NCH*DW-1:0] v;
        for (int i = 0; i < NCH; i++) v[i*DW +: DW] = dac_m[i];
        return v;
    endfunction

    function automatic void model_word(input logic [15:0] w);
        logic [3:0] c = w[15:12];
        if (c < 4'd8) stage_m[c[2:0]] = w[11:0];
        else if (c == 4'd8) for (int i = 0; i < NCH; i++) dac_m[i] = stage_m[i];
        else if (c == 4'd9) for (int i = 0; i < NCH; i++) begin
            stage_m[i] = w[11:0];
            dac_m[i]   = w[11:0];
        end
    endfunction

    function automatic void model_follow();
        if (!xfer_n) for (int i = 0; i < NCH; i++) dac_m[i] = stage_m[i];
    endfunction

    task automatic check_codes(input string tag);
        logic [NCH*DW-1:0] exp_v = packed_model();
        checks++;
        if (dac_code !== exp_v) begin
            fails++;
            $display("FAIL %s dac_code actual=%h expected=%h", tag, dac_code, exp_v);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp_b);
        checks++;
        if (act !== exp_b) begin
            fails++;
            $display("FAIL %s chain_out actual=%b expected=%b", tag, act, exp_b);
        end
    endtask

    // sends n bits, MSB of the n-bit field first; checks cascade output for bits past 16
    task automatic send_bits(input logic [31:0] bits, input int n);
        frame_n = 1'b0;
        tick(4);
        for (int k = 0; k < n; k++) begin
            ser_data = bits[n-1-k];
            tick(2);
            ser_clk = 1'b0;
            tick(4);
            if (k >= 16) check_bit("R10", chain_out, bits[n-1-(k-16)]);
            ser_clk = 1'b1;
            tick(2);
        end
        tick(2);
        frame_n = 1'b1;
        tick(8);
    endtask

    task automatic send_word(input logic [15:0] w);
        send_bits({16'h0, w}, 16);
        model_word(w);
        model_follow();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic chain_hold;
        int unsigned seed_dummy;
        rst_n = 1'b0; wipe_n = 1'b1; xfer_n = 1'b1;
        frame_n = 1'b1; ser_clk = 1'b1; ser_data = 1'b0;
        for (int i = 0; i < NCH; i++) begin stage_m[i] = '0; dac_m[i] = '0; end
        tick(5);
        check_codes("R1");
        check_bit("R1", chain_out, 1'b0);
        rst_n = 1'b1;
        tick(3);

        // R2 / R3: single-channel writes do not reach outputs
        send_word(16'h3ABC);
        check_codes("R3");
        send_word(16'h0001);
        send_word(16'h7FFF);
        check_codes("R3");
        // R4: copy all
        send_word(16'h8000);
        check_codes("R4 R2");

        // R6: unused commands
        for (int c = 10; c < 16; c++) send_word({c[3:0], 12'h5A5});
        send_word(16'h8000);
        check_codes("R6");

        // R7: wrong bit counts are dropped
        send_bits({17'h0, 15'h1555}, 15);
        send_bits({15'h0, 17'h02222}, 17);
        send_word(16'h8000);
        check_codes("R7");

        // R5: broadcast
        send_word(16'h9123);
        check_codes("R5");

        // R11: serial clocks outside a frame
        chain_hold = chain_out;
        for (int k = 0; k < 10; k++) begin
            ser_data = k[0];
            tick(2); ser_clk = 1'b0; tick(4); ser_clk = 1'b1; tick(2);
        end
        check_bit("R11", chain_out, chain_hold);
        check_codes("R11");

        // R10: 32-bit frame shows the first word on the chain, and is dropped (R7)
        send_bits({16'h2456, 16'h9ABC}, 32);
        check_codes("R7 long");

        // R8: transparent transfer
        send_word(16'h4321);
        xfer_n = 1'b0;
        tick(6);
        model_follow();
        check_codes("R8");
        send_word(16'h5777);
        check_codes("R8 write");
        xfer_n = 1'b1;
        tick(6);

        // R9: asynchronous wipe
        wipe_n = 1'b0;
        #1;
        for (int i = 0; i < NCH; i++) begin stage_m[i] = '0; dac_m[i] = '0; end
        check_codes("R9");
        tick(3);
        wipe_n = 1'b1;
        tick(3);
        send_word(16'h8000);
        check_codes("R9 stage");

        // constrained random traffic
        seed_dummy = $urandom(32'h0000_5EED);
        for (int n = 0; n < 150; n++) begin
            logic [15:0] w;
            w = 16'($urandom);
            if ((n % 3) == 0) w[15:12] = 4'($urandom % 10);
            if ((n % 16) == 15) begin
                xfer_n = 1'b0;
                tick(6);
                model_follow();
            end
            send_word(w);
            check_codes((w[15:12] == 4'd8) ? "R4" : (w[15:12] == 4'd9) ? "R5" :
                        (w[15:12] > 4'd9) ? "R6" : (xfer_n ? "R3" : "R8"));
            if (!xfer_n) begin
                xfer_n = 1'b1;
                tick(6);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule